// File: doc/BRIEF.md
# Paged Effective Address Generator

This block turns a memory reference instruction into the 12-bit address of its operand. The machine it serves is word-addressed, with a 4096-word memory split into 32 pages of 128 words. An instruction carries a 7-bit offset within a page and a flag that picks page zero or the page the instruction came from. A second flag makes the reference indirect. In that case the word at the directly formed address is read, and its full 12-bit contents become the operand address.

Eight page-zero words, octal 10 to 17, act as auto-incrementing pointers. When an indirect reference lands on one of them, the pointer is incremented by one, wrapping modulo 4096. The new value is written back to the same word and is also the resulting address.

A sequencer pulses `start` with the instruction and the address it was fetched from. It then waits for `done`, which reports the address on `ea`. The block owns a simple synchronous memory port: a read returns data one clock after the read strobe.

Top module: `page_ea_gen`

## Requirements
- R1: While reset is asserted and after it is released, `done` and `busy` are 0, `ea` is 0, and neither memory strobe is active until a start is accepted.
- R2: The in-page offset is `instr[6:0]` (instruction bits 5 to 11, counting bit 0 as the most significant), and it forms the low 7 bits of the direct address.
- R3: When `instr[7]` (page flag) is 1, the upper 5 bits of the direct address are `pc[11:7]`. When it is 0, they are zero.
- R4: When `instr[8]` (indirect flag) is 1, the word at the direct address is read, and `ea` becomes its 12-bit contents.
- R5: An indirect reference whose direct address is octal 10 to 17 yields the stored word plus one, modulo 4096 (octal 777 gives 1000, 7777 gives 0). That value is written back to the same address. No write ever goes anywhere else.
- R6: A direct reference makes no memory access. `done` is high in the cycle after the clock edge that accepts `start`.
- R7: An indirect reference asserts the read strobe with the direct address in the cycle `start` is accepted. `busy` is high in the next cycle, with at most one write there, and `done` follows one cycle after that.
- R8: `start` is ignored while `busy` is high. The pending result is not changed by the instruction presented then.
- R9: `done` is a one-cycle pulse, and `ea` holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to resolve `instr`, accepted when idle |
| instr | input | 12 | Memory reference instruction word |
| pc | input | 12 | Address the instruction was fetched from |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory address for read or write |
| mem_wdata | output | 12 | Write data (incremented pointer) |
| mem_rdata | input | 12 | Read data, valid the cycle after `mem_rd_en` |
| busy | output | 1 | Indirect reference in progress |
| done | output | 1 | One-cycle pulse, `ea` is valid |
| ea | output | 12 | Effective address |

## Verification
A direct reference is due one cycle after the accepting edge. An indirect or auto-increment reference is due two cycles after it. The bench drives `start` on a falling edge and counts rising edges until it sees `done` at the next falling edge. It compares that count with the expected latency of 1 or 2 and checks `ea` at that same sample point. Memory strobes are counted on rising edges for each request, and pointer write-backs are checked by reading the bench memory after the request completes.

// File: rtl/page_ea_gen.sv
module page_ea_gen #(
  parameter int AW       = 12,
  parameter int OFS_W    = 7,
  parameter int AUTO_LO  = 8,
  parameter int AUTO_CNT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] instr,
  input  logic [AW-1:0] pc,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea
);
  localparam int PG_W    = AW - OFS_W;
  localparam int PG_BIT  = OFS_W;
  localparam int IND_BIT = OFS_W + 1;
  localparam logic [AW-1:0] AUTO_HI = AW'(AUTO_LO + AUTO_CNT - 1);

  logic          in_fetch;
  logic          auto_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] dir_addr;
  logic          is_ind, is_auto, accept;

  assign dir_addr = {instr[PG_BIT] ? pc[AW-1 -: PG_W] : {PG_W{1'b0}}, instr[OFS_W-1:0]};
  assign is_ind   = instr[IND_BIT];
  assign is_auto  = is_ind && dir_addr >= AW'(AUTO_LO) && dir_addr <= AUTO_HI;
  assign accept   = start && !in_fetch;

  assign busy      = in_fetch;
  assign mem_rd_en = accept && is_ind;
  assign mem_wr_en = in_fetch && auto_q;
  assign mem_addr  = in_fetch ? ptr_q : dir_addr;
  assign mem_wdata = mem_rdata + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_fetch <= 1'b0;
      auto_q   <= 1'b0;
      ptr_q    <= '0;
      done     <= 1'b0;
      ea       <= '0;
    end else begin
      done <= 1'b0;
      if (in_fetch) begin
        in_fetch <= 1'b0;
        done     <= 1'b1;
        ea       <= auto_q ? mem_wdata : mem_rdata;
      end else if (start) begin
        ptr_q  <= dir_addr;
        auto_q <= is_auto;
        if (is_ind) begin
          in_fetch <= 1'b1;
        end else begin
          done <= 1'b1;
          ea   <= dir_addr;
        end
      end
    end
  end

  assert_wr_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_addr >= AW'(AUTO_LO) && mem_addr <= AUTO_HI));

  assert_wr_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (done && ea == $past(mem_wdata)));

  assert_direct_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !instr[IND_BIT]) |-> (!mem_rd_en && !mem_wr_en));

  assert_direct_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !instr[IND_BIT]) |=> (done && !busy));

  assert_indirect_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && instr[IND_BIT]) |=> (busy && !done && !mem_rd_en));

  assert_busy_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy));

  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_rd_en);

  assert_ea_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
endmodule

// File: tb/page_ea_gen_tb.sv
module page_ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] instr = '0;
  logic [11:0] pc = '0;
  logic        mem_rd_en, mem_wr_en, busy, done;
  logic [11:0] mem_addr, mem_wdata, mem_rdata, ea;

  logic [11:0] mem [4096];
  int errors = 0;
  int checks = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  page_ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .ea(ea)
  );

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  always @(posedge clk) begin
    if (mem_rd_en) rd_cnt++;
    if (mem_wr_en) wr_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%o expected=%o", req, act, exp);
    end
  endtask

  // instr, pc, expected ea, expected latency, expected reads, expected writes
  localparam int NV = 11;
  localparam logic [71:0] VEC [NV] = '{
    {12'o3350, 12'o0410, 12'o0550, 12'd1, 12'd0, 12'd0},
    {12'o3150, 12'o0410, 12'o0150, 12'd1, 12'd0, 12'd0},
    {12'o1377, 12'o7777, 12'o7777, 12'd1, 12'd0, 12'd0},
    {12'o3700, 12'o0410, 12'o2100, 12'd2, 12'd1, 12'd0},
    {12'o3450, 12'o0410, 12'o2100, 12'd2, 12'd1, 12'd0},
    {12'o3410, 12'o0200, 12'o1000, 12'd2, 12'd1, 12'd1},
    {12'o3410, 12'o5000, 12'o1001, 12'd2, 12'd1, 12'd1},
    {12'o3417, 12'o0000, 12'o0000, 12'd2, 12'd1, 12'd1},
    {12'o3407, 12'o0000, 12'o1234, 12'd2, 12'd1, 12'd0},
    {12'o3420, 12'o0000, 12'o4321, 12'd2, 12'd1, 12'd0},
    {12'o3610, 12'o0410, 12'o5555, 12'd2, 12'd1, 12'd0}
  };

  task automatic run(input logic [11:0] i, input logic [11:0] p,
                     output int lat, output logic [11:0] res);
    @(negedge clk);
    rd_cnt = 0;
    wr_cnt = 0;
    instr = i;
    pc = p;
    start = 1'b1;
    lat = 0;
    res = '0;
    for (int n = 1; n <= 8; n++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (done) begin
        lat = n;
        res = ea;
        break;
      end
    end
  endtask

  initial begin
    for (int k = 0; k < 4096; k++) mem[k] = 12'(k ^ 12'o5252);
    mem[12'o0010] = 12'o0777;
    mem[12'o0017] = 12'o7777;
    mem[12'o0007] = 12'o1234;
    mem[12'o0020] = 12'o4321;
    mem[12'o0050] = 12'o2100;
    mem[12'o0500] = 12'o2100;
    mem[12'o0410] = 12'o5555;

    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 ea in reset", int'(ea), 0);
    rst_n = 1'b1;
    rd_cnt = 0;
    wr_cnt = 0;
    repeat (2) @(negedge clk);
    chk("R1 no strobes after reset", rd_cnt + wr_cnt, 0);
    chk("R1 ea after reset", int'(ea), 0);

    for (int v = 0; v < NV; v++) begin
      int lat;
      logic [11:0] res;
      run(VEC[v][71:60], VEC[v][59:48], lat, res);
      chk("R2 R3 R4 R5 ea", int'(res), int'(VEC[v][47:36]));
      chk("R6 R7 latency", lat, int'(VEC[v][35:24]));
      chk("R6 R7 reads", rd_cnt, int'(VEC[v][23:12]));
      chk("R5 writes", wr_cnt, int'(VEC[v][11:0]));
    end

    chk("R5 pointer 10 written back", int'(mem[12'o0010]), 'o1001);
    chk("R5 pointer 17 wraps", int'(mem[12'o0017]), 'o0000);
    chk("R5 word 07 untouched", int'(mem[12'o0007]), 'o1234);
    chk("R5 word 20 untouched", int'(mem[12'o0020]), 'o4321);
    chk("R5 current page 0410 untouched", int'(mem[12'o0410]), 'o5555);

    // R8: a second request while busy is ignored
    @(negedge clk);
    instr = 12'o3450;
    pc = 12'o0000;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R8 busy during indirect", int'(busy), 1);
    instr = 12'o3177;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R8 done after busy", int'(done), 1);
    chk("R8 pending result kept", int'(ea), 'o2100);
    @(posedge clk);
    @(negedge clk);
    chk("R9 done single pulse", int'(done), 0);
    chk("R9 ea held", int'(ea), 'o2100);

    // R9: back-to-back direct, ea holds between completions
    begin
      int lat;
      logic [11:0] res;
      run(12'o3301, 12'o7600, lat, res);
      chk("R3 top page direct", int'(res), 'o7701);
      repeat (3) @(negedge clk);
      chk("R9 ea holds idle", int'(ea), 'o7701);
      chk("R9 done low idle", int'(done), 0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule